// File: doc/BRIEF.md
# Toggled Index/Data Register Port

This block is a host-side register interface that uses one write address for two jobs. A hidden toggle decides what each write on that address means. In the index phase the byte selects a register and also sets a video-enable control. In the data phase the byte is stored into the selected register. Every write on the shared address flips the toggle.

Host software that loses track of the toggle reads a separate status address. That read returns the synchronised vertical-sync level and, as a side effect, puts the toggle back into the index phase. A second read address returns the contents of the currently selected register and leaves the toggle alone. The register file holds twenty 8-bit registers at indices 00h to 13h. Two of them are also wired out to the display pipeline:
- the mode register at 10h, whose bit 5 requests that the split region is not panned;
- the pan register at 13h, which holds a 3-bit pixel-pan amount.

The toggle is a two-state machine with the states PH_INDEX and PH_DATA. These are its transitions:
- A status read goes to PH_INDEX from either state, and this transition has priority over the others.
- A write on the shared address in PH_INDEX goes to PH_DATA.
- A write on the shared address in PH_DATA goes to PH_INDEX.
- In any other cycle the state holds.

Top module: `ixp_port`

## Requirements
- R1: After reset the toggle is in the index phase, the index is 0, video_on is 1, every register is 0, rd_data is 0, pan_suppress is 0 and pel_pan is 0.
- R2: A write to wr_addr 0 in the index phase takes bits 4:0 as the register index and bit 5 as the video-enable control, discards bits 7:6, and moves the toggle to the data phase.
- R3: video_on is bit 5 of the most recent index-phase write: 1 keeps video on and 0 blanks the display. It changes on the clock edge that takes that write.
- R4: A write to wr_addr 0 in the data phase stores the byte into the selected register and returns the toggle to the index phase. The index and video_on are unchanged.
- R5: A read with rd_addr 1 returns the selected register on rd_data in the cycle after the read strobe, and it does not change the toggle. For indices 14h to 1Fh a read returns 0 and a data-phase write changes no register. rd_data holds its value when there is no read.
- R6: A read with rd_addr 2 puts the toggle in the index phase. When a shared-address write falls in the same cycle, that write is handled according to the phase before the edge, and the toggle still ends in the index phase.
- R7: A status read returns vsync_in in bit 3, delayed by two bus-clock flops, and all other bits are 0. A level applied before edge k is first seen by a read taken at edge k+2.
- R8: pan_suppress equals bit 5 of register 10h. Register 13h keeps only bits 2:0 of a written byte and reads back 0 in bits 7:3. pel_pan equals those three bits.
- R9: A read with rd_addr 0 returns video_on in bit 5 and the index in bits 4:0, with the other bits 0. A read with rd_addr 3 returns 0. Writes to wr_addr 1, 2 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address; 0 is the shared index/data address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 index readback, 1 selected register, 2 status, 3 none |
| rd_data | output | 8 | Registered read result, valid the cycle after rd_en |
| vsync_in | input | 1 | Asynchronous vertical-sync level from display timing |
| video_on | output | 1 | Video-enable control from the last index write |
| pan_suppress | output | 1 | Split-region pan suppression, bit 5 of register 10h |
| pel_pan | output | 3 | Pixel-pan amount from register 13h |

## Verification
The write and read ports are separate, so in a single cycle a status read can coincide with a write on the shared address. In that case the toggle advance and the toggle reset compete for the same state register. The bench provokes this collision once with the toggle in the index phase and once with it in the data phase. In each case it then checks where the byte landed and whether the next shared-address write is taken as an index. The behavioural reference model makes the same judgement on every clock, by applying the write against the old phase and letting the status reset win.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    localparam logic [1:0] WA_SHARED = 2'd0;
    localparam logic [1:0] RA_INDEX  = 2'd0;
    localparam logic [1:0] RA_DATA   = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;
endpackage

// File: rtl/ixp_sync.sv
module ixp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    // R7: first stage samples the asynchronous level one edge later
    p_first_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> chain_q[0] == $past(async_in));
endmodule

// File: rtl/ixp_phase.sv
module ixp_phase
    import ixp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_wr,
    input  logic status_rd,
    output logic in_data
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (status_rd) begin
            state_d = PH_INDEX;
        end else if (port_wr) begin
            unique case (state_q)
                PH_INDEX: state_d = PH_DATA;
                PH_DATA:  state_d = PH_INDEX;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_INDEX;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_INDEX: in_data = 1'b0;
            PH_DATA:  in_data = 1'b1;
        endcase
    end

    p_index_to_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !status_rd && state_q == PH_INDEX) |=> state_q == PH_DATA);
    p_data_to_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !status_rd && state_q == PH_DATA) |=> state_q == PH_INDEX);
    p_status_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> state_q == PH_INDEX);
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_wr && !status_rd) |=> $stable(state_q));
endmodule

// File: rtl/ixp_regfile.sv
module ixp_regfile #(
    parameter int DW       = 8,
    parameter int IW       = 5,
    parameter int NREGS    = 20,
    parameter int MODE_IDX = 16,
    parameter int PAN_IDX  = 19,
    parameter int PAN_W    = 3,
    parameter int SUPP_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             suppress,
    output logic [PAN_W-1:0] pan
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NREGS - 1);

    logic [NREGS-1:0][DW-1:0] regs_q;
    logic                     hit;

    assign hit = (idx <= LAST_IDX);

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            if (g == PAN_IDX) begin : g_pan
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        regs_q[g] <= '0;
                    else if (we && idx == IW'(g))
                        regs_q[g] <= DW'(wdata[PAN_W-1:0]);
                end
            end else begin : g_full
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        regs_q[g] <= '0;
                    else if (we && idx == IW'(g))
                        regs_q[g] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (hit) rdata = regs_q[idx];
    end

    assign suppress = regs_q[MODE_IDX][SUPP_BIT];
    assign pan      = regs_q[PAN_IDX][PAN_W-1:0];

    p_unimpl_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> $stable(regs_q));
    p_pan_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IW'(PAN_IDX)) |=> regs_q[PAN_IDX][DW-1:PAN_W] == '0);
endmodule

// File: rtl/ixp_port.sv
module ixp_port
    import ixp_pkg::*;
#(
    parameter int DW        = 8,
    parameter int IW        = 5,
    parameter int NREGS     = 20,
    parameter int MODE_IDX  = 16,
    parameter int PAN_IDX   = 19,
    parameter int PAN_W     = 3,
    parameter int SUPP_BIT  = 5,
    parameter int VIDEO_BIT = 5,
    parameter int VS_BIT    = 3,
    parameter int SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             vsync_in,
    output logic             video_on,
    output logic             pan_suppress,
    output logic [PAN_W-1:0] pel_pan
);
    logic          port_wr, status_rd, in_data, vs_sync;
    logic [IW-1:0] idx_q;
    logic          vid_q;
    logic [DW-1:0] sel_data, rd_d, rd_q;

    assign port_wr   = wr_en && (wr_addr == WA_SHARED);
    assign status_rd = rd_en && (rd_addr == RA_STATUS);

    ixp_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_wr   (port_wr),
        .status_rd (status_rd),
        .in_data   (in_data)
    );

    ixp_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (vsync_in),
        .sync_out (vs_sync)
    );

    ixp_regfile #(
        .DW(DW), .IW(IW), .NREGS(NREGS), .MODE_IDX(MODE_IDX),
        .PAN_IDX(PAN_IDX), .PAN_W(PAN_W), .SUPP_BIT(SUPP_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (port_wr && in_data),
        .idx      (idx_q),
        .wdata    (wr_data),
        .rdata    (sel_data),
        .suppress (pan_suppress),
        .pan      (pel_pan)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            vid_q <= 1'b1;
        end else if (port_wr && !in_data) begin
            idx_q <= wr_data[IW-1:0];
            vid_q <= wr_data[VIDEO_BIT];
        end
    end

    always_comb begin
        rd_d = '0;
        unique case (rd_addr)
            RA_INDEX: begin
                rd_d[IW-1:0]    = idx_q;
                rd_d[VIDEO_BIT] = vid_q;
            end
            RA_DATA:   rd_d = sel_data;
            RA_STATUS: rd_d[VS_BIT] = vs_sync;
            default:   rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_d;
    end

    assign rd_data  = rd_q;
    assign video_on = vid_q;

    p_video_from_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !in_data) |=> video_on == $past(wr_data[VIDEO_BIT]));
    p_data_read_keeps_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == RA_DATA && !port_wr) |=> in_data == $past(in_data));
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_other_writes_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != WA_SHARED && !rd_en) |=> $stable(idx_q) && $stable(in_data));
endmodule

// File: tb/ixp_port_test.sv
module ixp_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       vsync_in = 1'b0;
    logic       video_on, pan_suppress;
    logic [2:0] pel_pan;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;

    ixp_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .vsync_in(vsync_in), .video_on(video_on), .pan_suppress(pan_suppress),
        .pel_pan(pel_pan)
    );

    // behavioural reference model
    int m_regs [0:19];
    int m_idx = 0, m_vid = 1, m_data = 0, m_rd = 0, m_s1 = 0, m_s2 = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 20; i++) m_regs[i] = 0;
            m_idx = 0; m_vid = 1; m_data = 0; m_rd = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int n_rd;
            n_rd = m_rd;
            if (rd_en) begin
                case (rd_addr)
                    2'd0: n_rd = m_vid * 32 + m_idx;
                    2'd1: n_rd = (m_idx < 20) ? m_regs[m_idx] : 0;
                    2'd2: n_rd = m_s2 ? 8 : 0;
                    default: n_rd = 0;
                endcase
            end
            if (wr_en && wr_addr == 2'd0) begin
                if (m_data == 0) begin
                    m_idx = wr_data % 32;
                    m_vid = wr_data[5];
                end else if (m_idx < 20) begin
                    m_regs[m_idx] = (m_idx == 19) ? (wr_data % 8) : wr_data;
                end
                m_data = 1 - m_data;
            end
            if (rd_en && rd_addr == 2'd2) m_data = 0;
            m_s2 = m_s1;
            m_s1 = vsync_in;
            m_rd = n_rd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5 model rd_data", rd_data, m_rd);
            chk("R3 model video_on", video_on, m_vid);
            chk("R8 model pan_suppress", pan_suppress, (m_regs[16] / 32) % 2);
            chk("R8 model pel_pan", pel_pan, m_regs[19] % 8);
        end
    end

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R1 reset state
        chk("R1 video_on", video_on, 1);
        chk("R1 pel_pan", pel_pan, 0);
        chk("R1 pan_suppress", pan_suppress, 0);
        chk("R1 rd_data", rd_data, 0);
        rd(2'd0);
        chk("R1 index readback", rd_data, 8'h20);

        // R2 index write, R8 pan register masking, R4 return to index
        wr(2'd0, 8'h33);
        rd(2'd0);
        chk("R2 index readback", rd_data, 8'h33);
        wr(2'd0, 8'hFF);
        chk("R8 pel_pan", pel_pan, 7);
        rd(2'd1);
        chk("R8 pan reg read", rd_data, 8'h07);
        rd(2'd0);
        chk("R4 index kept", rd_data, 8'h33);

        // R3 blanking, R8 suppress bit, R5 reads keep phase
        wr(2'd0, 8'h10);
        chk("R3 video blanked", video_on, 0);
        wr(2'd0, 8'h20);
        chk("R8 pan_suppress", pan_suppress, 1);
        rd(2'd1);
        rd(2'd1);
        chk("R5 repeat data read", rd_data, 8'h20);
        wr(2'd0, 8'hE5);
        chk("R3 video on", video_on, 1);
        rd(2'd0);
        chk("R2 bits 7:6 dropped", rd_data, 8'h25);
        wr(2'd0, 8'hA5);
        rd(2'd1);
        chk("R4 data stored", rd_data, 8'hA5);

        // R6 status read resets toggle
        wr(2'd0, 8'h24);
        rd(2'd2);
        wr(2'd0, 8'h27);
        rd(2'd0);
        chk("R6 write after status is index", rd_data, 8'h27);
        rd(2'd2);

        // R6 collision in index phase
        rd_en = 1'b1; rd_addr = 2'd2;
        wr(2'd0, 8'h21);
        rd_en = 1'b0;
        wr(2'd0, 8'h22);
        rd(2'd0);
        chk("R6 collision index phase", rd_data, 8'h22);

        // R6 collision in data phase
        rd_en = 1'b1; rd_addr = 2'd2;
        wr(2'd0, 8'h5A);
        rd_en = 1'b0;
        rd(2'd1);
        chk("R6 collision data stored", rd_data, 8'h5A);
        wr(2'd0, 8'h23);
        rd(2'd0);
        chk("R6 collision left index phase", rd_data, 8'h23);
        rd(2'd2);

        // R5 unimplemented index
        wr(2'd0, 8'h3F);
        wr(2'd0, 8'h77);
        rd(2'd1);
        chk("R5 unimplemented reads zero", rd_data, 0);
        chk("R5 pel_pan untouched", pel_pan, 7);
        chk("R5 pan_suppress untouched", pan_suppress, 1);
        wr(2'd0, 8'h33);
        rd(2'd1);
        chk("R5 pan reg untouched", rd_data, 8'h07);

        // R9 writes elsewhere ignored, phase still data
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h02);
        chk("R9 ignored writes", pel_pan, 2);
        rd(2'd3);
        chk("R9 address 3 reads zero", rd_data, 0);
        rd(2'd0);
        chk("R9 index readback", rd_data, 8'h33);

        // R7 vertical sync through two flops
        vsync_in = 1'b1;
        rd(2'd2);
        chk("R7 edge 1", rd_data, 0);
        rd(2'd2);
        chk("R7 edge 2", rd_data, 0);
        rd(2'd2);
        chk("R7 edge 3", rd_data, 8'h08);
        vsync_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd2);
        chk("R7 low again", rd_data, 0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule